// File: doc/BRIEF.md
# Instruction Repeat Sequencer

This decode-stage block accepts one decoded instruction at a time and sends micro-ops downstream over a valid/ready stream. Most instructions pass through as a single micro-op. An instruction that the decoder flags for repetition is sent as two micro-ops in back-to-back issue slots.

Quad-width (16-byte) loads and stores work on an even/odd register pair. For these, each iteration selects one register of the pair, and the current byte order decides which register comes first. The second iteration tells the memory stage to move to the next doubleword. A branch that writes both the count and the link register is split as well: the first micro-op updates the count register, and the second updates the link register.

The block also catches illegal register overlaps in quad loads. It catches misaligned quad loads in little-endian mode too. Either case is reported on a single flagged micro-op, and no pair is issued.

Top module: `uop_repeat_seq`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high while flush_i is low.
- R2: An instruction with in_repeat_i low produces exactly one micro-op. Kind, register, ra and rb are copied, repeat, second and next-doubleword are 0, and interrupt-allowed is 1. For kind 5 alone, count-update and link-update are both 1 on this single op.
- R3: A repeated instruction with no exception produces exactly two micro-ops in order. Repeat is 1 on both. Second is 1 only on the later one. Interrupt-allowed is 1 on the first and 0 on the second.
- R4: With in_be_i = 0 (little-endian) and a quad kind (1 to 4), the first micro-op's register is rt with bit 0 set, and the second micro-op's register is rt unchanged.
- R5: With in_be_i = 1 (big-endian) and a quad kind, the first micro-op's register is rt unchanged, and the second micro-op's register is rt with bit 0 set.
- R6: Next-doubleword is 1 only on the second micro-op of a repeated quad kind. It is 0 for every other micro-op, including both halves of a kind-5 split.
- R7: For a repeated kind 5 (count-and-link branch), the first micro-op has count-update 1 and link-update 0. The second has count-update 0 and link-update 1. The register is rt on both.
- R8: A micro-op is flagged illegal in two cases: kind 1 (quad load) with rt equal to ra, and kind 2 (reserved quad load) with ra or rb equal to rt. An illegal instruction is sent as a single micro-op with illegal 1 and repeat 0.
- R9: Kinds 1 and 2 with in_be_i = 0 and a nonzero in_addr_lo_i (the low log2(16) address bits) raise the alignment flag and are sent as a single non-repeated micro-op. In big-endian mode there is no alignment flag. Illegal takes priority over alignment, so alignment is 0 whenever illegal is 1.
- R10: While the output holds the first micro-op of a pair, in_ready_o is low. The second micro-op follows in the cycle after the first is taken.
- R11: flush_i drops in_ready_o in the same cycle and clears out_valid_o at the next edge. A pending second micro-op is never emitted.
- R12: While out_valid_o is high and out_ready_i is low, every output field holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard the micro-op in flight and any pending second iteration |
| in_valid_i | input | 1 | Incoming instruction valid |
| in_ready_o | output | 1 | Block can accept an instruction |
| in_kind_i | input | 3 | 0 plain, 1 quad load, 2 reserved quad load, 3 quad store, 4 conditional quad store, 5 count-and-link branch |
| in_rt_i | input | 5 | Target or source data register |
| in_ra_i | input | 5 | Base register |
| in_rb_i | input | 5 | Index register |
| in_repeat_i | input | 1 | Decoder requests two iterations |
| in_be_i | input | 1 | 1 = big-endian mode |
| in_addr_lo_i | input | 4 | Low effective-address bits |
| out_valid_o | output | 1 | Micro-op valid |
| out_ready_i | input | 1 | Downstream accepts micro-op |
| out_kind_o | output | 3 | Kind of the micro-op |
| out_reg_o | output | 5 | Selected data register |
| out_ra_o | output | 5 | Base register |
| out_rb_o | output | 5 | Index register |
| out_repeat_o | output | 1 | Part of a repeated pair |
| out_second_o | output | 1 | Second iteration |
| out_next_dw_o | output | 1 | Memory stage uses base + 8 |
| out_irq_ok_o | output | 1 | Asynchronous and trace interrupts may be taken |
| out_illegal_o | output | 1 | Illegal register combination |
| out_align_o | output | 1 | Alignment exception |
| out_ctr_upd_o | output | 1 | Micro-op updates count register |
| out_lr_upd_o | output | 1 | Micro-op updates link register |

## Verification
Two things can collide in one cycle: a flush, and the handoff in which the stalled first half of a pair would be replaced by its second half. The bench provokes this by stalling the output on a first-half micro-op and then raising flush. It then checks three things: ready drops at once, the output empties, and no second half appears even after the stall is released. A second overlap is an instruction that is both illegal and misaligned. The bench judges it by checking that only the illegal flag is raised, on a single micro-op.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_PLAIN     = 3'd0,
    K_QLD       = 3'd1,
    K_QLD_RSV   = 3'd2,
    K_QST       = 3'd3,
    K_QST_CND   = 3'd4,
    K_BR_CTR_LR = 3'd5
  } kind_e;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    kind_e kind;
    reg_t  rt;
    reg_t  ra;
    reg_t  rb;
    logic  be;
  } instr_t;

  typedef struct packed {
    kind_e kind;
    reg_t  rsel;
    reg_t  ra;
    reg_t  rb;
    logic  rep;
    logic  second;
    logic  next_dw;
    logic  irq_ok;
    logic  illegal;
    logic  align;
    logic  ctr_upd;
    logic  lr_upd;
  } uop_t;

  function automatic logic is_quad(kind_e k);
    return (k == K_QLD) || (k == K_QLD_RSV) || (k == K_QST) || (k == K_QST_CND);
  endfunction

  function automatic logic is_quad_load(kind_e k);
    return (k == K_QLD) || (k == K_QLD_RSV);
  endfunction
endpackage

// File: rtl/rpt_classify.sv
module rpt_classify
  import rpt_pkg::*;
#(
  parameter int unsigned ADDR_LO_W = 4
) (
  input  instr_t               ins_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 rep_i,
  output logic                 illegal_o,
  output logic                 misalign_o,
  output logic                 pair_o
);
  logic ovl_plain, ovl_rsv;

  always_comb begin
    ovl_plain  = (ins_i.kind == K_QLD) && (ins_i.rt == ins_i.ra);
    ovl_rsv    = (ins_i.kind == K_QLD_RSV) &&
                 ((ins_i.ra == ins_i.rt) || (ins_i.rb == ins_i.rt));
    illegal_o  = ovl_plain || ovl_rsv;
    // only little-endian quad loads demand full alignment
    misalign_o = is_quad_load(ins_i.kind) && !ins_i.be && (addr_lo_i != '0);
    pair_o     = rep_i && !illegal_o && !misalign_o;
  end
endmodule

// File: rtl/rpt_uop_gen.sv
module rpt_uop_gen
  import rpt_pkg::*;
#(
  parameter bit SECOND = 1'b0
) (
  input  instr_t ins_i,
  input  logic   pair_i,
  input  logic   illegal_i,
  input  logic   misalign_i,
  output uop_t   uop_o
);
  always_comb begin
    uop_o         = '0;
    uop_o.kind    = ins_i.kind;
    uop_o.rsel    = ins_i.rt;
    uop_o.ra      = ins_i.ra;
    uop_o.rb      = ins_i.rb;
    uop_o.illegal = illegal_i;
    uop_o.align   = misalign_i && !illegal_i;
    uop_o.irq_ok  = !SECOND;
    if (pair_i) begin
      uop_o.rep    = 1'b1;
      uop_o.second = SECOND;
      if (is_quad(ins_i.kind)) begin
        // LE: odd half first; BE: odd half last
        if (ins_i.be == SECOND) uop_o.rsel[0] = 1'b1;
        uop_o.next_dw = SECOND;
      end
      if (ins_i.kind == K_BR_CTR_LR) begin
        uop_o.ctr_upd = !SECOND;
        uop_o.lr_upd  = SECOND;
      end
    end else if (ins_i.kind == K_BR_CTR_LR) begin
      uop_o.ctr_upd = 1'b1;
      uop_o.lr_upd  = 1'b1;
    end
  end
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flush_i,
  input  logic   in_valid_i,
  output logic   in_ready_o,
  input  instr_t ins_i,
  input  logic   pair_i,
  input  uop_t   first_uop_i,
  input  uop_t   second_uop_i,
  output instr_t hold_o,
  output logic   out_valid_o,
  input  logic   out_ready_i,
  output uop_t   out_uop_o
);
  logic   vld_q, pend_q;
  uop_t   out_q;
  instr_t hold_q;
  logic   fire_out, accept;

  assign fire_out   = vld_q && out_ready_i;
  assign in_ready_o = !flush_i && !pend_q && (!vld_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= '0;
      hold_q <= '0;
    end else if (flush_i) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (fire_out) begin
        out_q  <= second_uop_i;
        pend_q <= 1'b0;
      end
    end else if (accept) begin
      vld_q  <= 1'b1;
      out_q  <= first_uop_i;
      pend_q <= pair_i;
      hold_q <= ins_i;
    end else if (fire_out) begin
      vld_q <= 1'b0;
    end
  end

  assign hold_o      = hold_q;
  assign out_valid_o = vld_q;
  assign out_uop_o   = out_q;
endmodule

// File: rtl/uop_repeat_seq.sv
module uop_repeat_seq
  import rpt_pkg::*;
#(
  parameter int unsigned ALIGN_BYTES = 16,
  localparam int unsigned ADDR_LO_W = $clog2(ALIGN_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [KIND_W-1:0]    in_kind_i,
  input  logic [REG_W-1:0]     in_rt_i,
  input  logic [REG_W-1:0]     in_ra_i,
  input  logic [REG_W-1:0]     in_rb_i,
  input  logic                 in_repeat_i,
  input  logic                 in_be_i,
  input  logic [ADDR_LO_W-1:0] in_addr_lo_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [KIND_W-1:0]    out_kind_o,
  output logic [REG_W-1:0]     out_reg_o,
  output logic [REG_W-1:0]     out_ra_o,
  output logic [REG_W-1:0]     out_rb_o,
  output logic                 out_repeat_o,
  output logic                 out_second_o,
  output logic                 out_next_dw_o,
  output logic                 out_irq_ok_o,
  output logic                 out_illegal_o,
  output logic                 out_align_o,
  output logic                 out_ctr_upd_o,
  output logic                 out_lr_upd_o
);
  instr_t in_ins, hold;
  logic   illegal, misalign, pair;
  uop_t   gen_uop [2];
  uop_t   out_uop;

  assign in_ins = '{kind: kind_e'(in_kind_i), rt: in_rt_i, ra: in_ra_i,
                    rb: in_rb_i, be: in_be_i};

  rpt_classify #(.ADDR_LO_W(ADDR_LO_W)) u_cls (
    .ins_i     (in_ins),
    .addr_lo_i (in_addr_lo_i),
    .rep_i     (in_repeat_i),
    .illegal_o (illegal),
    .misalign_o(misalign),
    .pair_o    (pair)
  );

  // phase 0 builds from the live input, phase 1 from the held copy
  for (genvar p = 0; p < 2; p++) begin : g_phase
    rpt_uop_gen #(.SECOND(p == 1)) u_gen (
      .ins_i     (p == 0 ? in_ins : hold),
      .pair_i    (p == 0 ? pair : 1'b1),
      .illegal_i (p == 0 ? illegal : 1'b0),
      .misalign_i(p == 0 ? misalign : 1'b0),
      .uop_o     (gen_uop[p])
    );
  end

  rpt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .ins_i       (in_ins),
    .pair_i      (pair),
    .first_uop_i (gen_uop[0]),
    .second_uop_i(gen_uop[1]),
    .hold_o      (hold),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_uop_o   (out_uop)
  );

  assign out_kind_o    = out_uop.kind;
  assign out_reg_o     = out_uop.rsel;
  assign out_ra_o      = out_uop.ra;
  assign out_rb_o      = out_uop.rb;
  assign out_repeat_o  = out_uop.rep;
  assign out_second_o  = out_uop.second;
  assign out_next_dw_o = out_uop.next_dw;
  assign out_irq_ok_o  = out_uop.irq_ok;
  assign out_illegal_o = out_uop.illegal;
  assign out_align_o   = out_uop.align;
  assign out_ctr_upd_o = out_uop.ctr_upd;
  assign out_lr_upd_o  = out_uop.lr_upd;
endmodule

// File: rtl/rpt_seq_chk.sv
module rpt_seq_chk
  import rpt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [REG_W-1:0]  out_reg_o,
  input logic              out_repeat_o,
  input logic              out_second_o,
  input logic              out_next_dw_o,
  input logic              out_irq_ok_o,
  input logic              out_illegal_o,
  input logic              out_align_o,
  input logic              out_ctr_upd_o,
  input logic              out_lr_upd_o
);
  p_second_in_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_second_o |-> out_repeat_o && !out_irq_ok_o);

  p_next_dw_second_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_next_dw_o |-> out_second_o);

  p_split_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_repeat_o |-> !(out_ctr_upd_o && out_lr_upd_o));

  p_exc_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_illegal_o || out_align_o) |-> !out_repeat_o);

  p_illegal_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_illegal_o && out_align_o));

  p_hold_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_repeat_o && !out_second_o |-> !in_ready_o);

  p_second_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_repeat_o && !out_second_o && !flush_i
    |=> out_valid_o && out_second_o);

  p_flush_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !in_ready_o);

  p_flush_empties_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);

  p_stall_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !flush_i
    |=> out_valid_o && $stable(out_reg_o) && $stable(out_second_o) && $stable(out_repeat_o));
endmodule

bind uop_repeat_seq rpt_seq_chk u_chk (.*);

// File: tb/sim_uop_repeat_seq.sv
`timescale 1ns/1ps
module sim_uop_repeat_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       flush_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [2:0] in_kind_i = '0;
  logic [4:0] in_rt_i = '0, in_ra_i = '0, in_rb_i = '0;
  logic       in_repeat_i = 1'b0, in_be_i = 1'b0;
  logic [3:0] in_addr_lo_i = '0;
  logic       out_valid_o, out_ready_i;
  logic [2:0] out_kind_o;
  logic [4:0] out_reg_o, out_ra_o, out_rb_o;
  logic out_repeat_o, out_second_o, out_next_dw_o, out_irq_ok_o;
  logic out_illegal_o, out_align_o, out_ctr_upd_o, out_lr_upd_o;

  uop_repeat_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_kind_i(in_kind_i), .in_rt_i(in_rt_i), .in_ra_i(in_ra_i), .in_rb_i(in_rb_i),
    .in_repeat_i(in_repeat_i), .in_be_i(in_be_i), .in_addr_lo_i(in_addr_lo_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_kind_o(out_kind_o), .out_reg_o(out_reg_o), .out_ra_o(out_ra_o), .out_rb_o(out_rb_o),
    .out_repeat_o(out_repeat_o), .out_second_o(out_second_o), .out_next_dw_o(out_next_dw_o),
    .out_irq_ok_o(out_irq_ok_o), .out_illegal_o(out_illegal_o), .out_align_o(out_align_o),
    .out_ctr_upd_o(out_ctr_upd_o), .out_lr_upd_o(out_lr_upd_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [25:0] exp_q[$];
  string       tag_q[$];

  bit bp_mode = 1'b0, stall = 1'b0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    out_ready_i = stall ? 1'b0 : (bp_mode ? (cyc % 3 != 1) : 1'b1);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [25:0] pack(input logic [2:0] k, input logic [4:0] r,
      input logic [4:0] a, input logic [4:0] b, input logic rp, input logic sc,
      input logic nd, input logic iq, input logic il, input logic al,
      input logic ct, input logic lr);
    return {k, r, a, b, rp, sc, nd, iq, il, al, ct, lr};
  endfunction

  function automatic logic [25:0] port_vec();
    return pack(out_kind_o, out_reg_o, out_ra_o, out_rb_o, out_repeat_o, out_second_o,
                out_next_dw_o, out_irq_ok_o, out_illegal_o, out_align_o,
                out_ctr_upd_o, out_lr_upd_o);
  endfunction

  // expected micro-ops built from the requirements
  task automatic push_exp(input int k, input logic [4:0] rt, input logic [4:0] ra,
      input logic [4:0] rb, input bit rep, input bit be, input logic [3:0] alo,
      input string tag);
    bit ill, mis, quad;
    ill  = (k == 1 && rt == ra) || (k == 2 && (ra == rt || rb == rt));
    mis  = !be && (k == 1 || k == 2) && alo != 0;
    quad = (k >= 1 && k <= 4);
    if (!(rep && !ill && !mis)) begin
      exp_q.push_back(pack(3'(k), rt, ra, rb, 0, 0, 0, 1, ill, mis && !ill,
                           k == 5, k == 5));
      tag_q.push_back(tag);
    end else begin
      for (int s = 0; s < 2; s++) begin
        bit setlsb;
        logic [4:0] r;
        setlsb = be ? (s == 1) : (s == 0);
        r = (quad && setlsb) ? (rt | 5'd1) : rt;
        exp_q.push_back(pack(3'(k), r, ra, rb, 1, s == 1, quad && s == 1, s == 0,
                             0, 0, k == 5 && s == 0, k == 5 && s == 1));
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic send(input int k, input logic [4:0] rt, input logic [4:0] ra,
      input logic [4:0] rb, input bit rep, input bit be, input logic [3:0] alo,
      input string tag);
    in_kind_i = 3'(k); in_rt_i = rt; in_ra_i = ra; in_rb_i = rb;
    in_repeat_i = rep; in_be_i = be; in_addr_lo_i = alo; in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin @(negedge clk); #1; end
    @(posedge clk);
    push_exp(k, rt, ra, rb, rep, be, alo, tag);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  logic [25:0] last_vec;
  bit          last_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (last_stall && !flush_i)
          chk(out_valid_o && port_vec() == last_vec, "R12", "stalled output moved",
              32'(port_vec()), 32'(last_vec));
        last_stall = out_valid_o && !out_ready_i && !flush_i;
        last_vec   = port_vec();
        if (out_valid_o && out_ready_i) begin
          if (exp_q.size() == 0) chk(0, "R3", "unexpected micro-op", 32'(port_vec()), 0);
          else begin
            logic [25:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(port_vec() == e, t, "micro-op mismatch", 32'(port_vec()), 32'(e));
          end
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R3", "micro-ops missing", exp_q.size(), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid_o == 0, "R1", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1, "R1", "in_ready after reset", in_ready_o, 1);

    // single ops (R2)
    send(0, 5'd9, 5'd1, 5'd2, 0, 0, 4'd0, "R2");
    send(1, 5'd6, 5'd3, 5'd0, 0, 0, 4'd0, "R2");
    send(5, 5'd0, 5'd0, 5'd0, 0, 1, 4'd0, "R2");

    // LE quad load pair with ready check on handoff (R4, R6, R10)
    send(1, 5'd6, 5'd3, 5'd0, 1, 0, 4'd0, "R4/R6");
    #1;
    chk(in_ready_o == 0, "R10", "ready during first of pair", in_ready_o, 0);
    @(negedge clk); #1;
    chk(out_valid_o && out_second_o, "R10", "second follows first",
        {out_valid_o, out_second_o}, 2'b11);
    drain();

    // BE orders, misalignment ignored in BE (R5, R9)
    send(1, 5'd10, 5'd3, 5'd4, 1, 1, 4'd4, "R5/R9");
    send(3, 5'd12, 5'd1, 5'd2, 1, 0, 4'd8, "R4");
    send(4, 5'd14, 5'd1, 5'd2, 1, 1, 4'd0, "R5");
    send(2, 5'd20, 5'd1, 5'd2, 1, 1, 4'd0, "R5");
    // count-and-link split (R7)
    send(5, 5'd7, 5'd0, 5'd0, 1, 0, 4'd0, "R7");
    // generic repeat of a plain kind (R3)
    send(0, 5'd8, 5'd1, 5'd2, 1, 0, 4'd0, "R3");
    // illegal (R8)
    send(1, 5'd4, 5'd4, 5'd0, 1, 0, 4'd0, "R8");
    send(2, 5'd6, 5'd1, 5'd6, 1, 1, 4'd0, "R8");
    // illegal and misaligned together: illegal wins (R9)
    send(2, 5'd2, 5'd2, 5'd1, 1, 0, 4'd3, "R9");
    // LE misaligned quad loads (R9)
    send(1, 5'd8, 5'd1, 5'd0, 1, 0, 4'd8, "R9");
    send(2, 5'd8, 5'd1, 5'd3, 1, 0, 4'd1, "R9");
    drain();

    // backpressure (R12)
    bp_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send(1 + (i % 4), 5'(2 * i + 2), 5'd1, 5'd31, 1, i[0], 4'd0, "R12/R3");
      send(5, 5'(i), 5'd0, 5'd0, i[1], 0, 4'd0, "R12/R7");
    end
    drain();
    bp_mode = 1'b0;

    // flush against pending second (R11)
    stall = 1'b1;
    @(negedge clk);
    send(1, 5'd16, 5'd2, 5'd0, 1, 1, 4'd0, "R11");
    flush_i = 1'b1;
    #1;
    chk(in_ready_o == 0, "R11", "ready during flush", in_ready_o, 0);
    @(negedge clk);
    flush_i = 1'b0;
    exp_q.delete(); tag_q.delete();
    #1;
    chk(out_valid_o == 0, "R11", "valid after flush", out_valid_o, 0);
    stall = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(out_valid_o == 0, "R11", "discarded second emitted", out_valid_o, 0);
    end
    send(3, 5'd18, 5'd1, 5'd0, 1, 0, 4'd0, "R11/R4");
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule